// File: doc/BRIEF.md
# PCM Data Word Serializer

This block turns a stream of parallel data words into the serial bit stream of a PCM frame. Every word is handed over together with its own descriptor: how many bits it carries, whether the most or the least significant bit goes first, whether a parity bit is added, where that bit goes, and whether the parity is odd or even. Because the descriptor comes with each word, consecutive words in a frame may differ in every one of these settings.

A bit-clock enable input sets the pace: each enable advances the line by one bit time. The block raises its ready output during the enable that ends the current word. If the producer offers a word at that moment, the first bit of that word follows the last bit of the previous word with no idle bit between them. The serial output is NRZ-L level data. It comes with a clock pulse whose rising edge lines up with every data transition.

Top module: `pcm_word_serializer`

## Requirements
- R1: The length field `word_lenm1` holds the word length minus one, so 0 to 31 gives 1 to 32 data bits. Bits of `word_data` at index equal to or above the length never reach the line.
- R2: With `word_lsb_first` = 1 the data bits go out from bit 0 upward. With 0 they go out from bit length-1 downward.
- R3: `word_par_mode` encodes the parity position: 0 = none, 1 = parity bit before the data, 2 = parity bit after the data, 3 = none. A word with parity occupies length+1 bit times; a word without parity occupies length bit times.
- R4: Parity is computed over the data bits inside the length only. With `word_par_odd` = 1 the data bits plus the parity bit hold an odd number of ones; with 0 they hold an even number.
- R5: Exactly one bit time passes per cycle with `bit_en` high. The first bit of a word appears on the clock edge of the enable that accepts it. `ser_data` and `ser_valid` hold their values through cycles without `bit_en`.
- R6: `word_ready` is high only while `bit_en` is high and the line is either idle or showing the last bit of the current word. A word is taken when `word_valid` and `word_ready` are both high, so back-to-back words have no gap bit.
- R7: When no word is in flight, `ser_valid`, `ser_data` and `ser_clk` are all 0.
- R8: `ser_clk` is high for exactly one clock cycle each time a new bit is placed on `ser_data`, and is low otherwise.
- R9: A synchronous active-low reset empties the block into the idle state of R7. The block is then ready on the first enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable, one bit time per high cycle |
| word_valid | input | 1 | A word and its descriptor are offered |
| word_data | input | 32 | Parallel data word, right aligned |
| word_lenm1 | input | 5 | Word length minus one |
| word_lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| word_par_mode | input | 2 | Parity position: 0 none, 1 leading, 2 trailing, 3 none |
| word_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| word_ready | output | 1 | Word is taken this cycle if offered |
| ser_data | output | 1 | NRZ-L serial data |
| ser_valid | output | 1 | A bit of a word is on the line |
| ser_clk | output | 1 | One-cycle pulse aligned to each new bit |

## Verification
The bench sends a chain of words back to back. These include 1-bit and 32-bit words, junk above the length, both bit orders, all four parity codes and both parity senses. It compares each assembled bit stream with a model built from the requirements. A block that dropped or added a parity slot would shift every later word by one bit. A block that reversed within the wrong width would show junk or zeros at the start of MSB-first words. A block that took the new word one enable late would put an idle bit between words and would also raise ready in the wrong cycle. Directed tests check that the outputs hold between enables, that the line goes quiet when no word follows, and that a reset in the middle of a word clears the line.

// File: rtl/pcm_ser_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the PCM word serializer.
// Assumes: the parity position field is two bits wide; code 3 behaves as "none".
package pcm_ser_pkg;

    // Parity placement codes carried in each word descriptor.
    typedef enum logic [1:0] {
        PAR_NONE     = 2'd0,
        PAR_LEAD     = 2'd1,
        PAR_TRAIL    = 2'd2,
        PAR_NONE_ALT = 2'd3
    } par_mode_e;

endpackage

// File: rtl/pcm_ser_order.sv
`timescale 1ns/1ps
// Module: pcm_ser_order
// Masks a word to its programmed length and puts its bits in send order,
// so that bit 0 of 'ordered' is the first data bit on the line.
// Assumes: lenm1 <= MAX_BITS-1; purely combinational.
module pcm_ser_order #(
    parameter int MAX_BITS = 32,
    localparam int LEN_W   = $clog2(MAX_BITS)
) (
    input  logic [MAX_BITS-1:0] data,
    input  logic [LEN_W-1:0]    lenm1,
    input  logic                lsb_first,
    output logic [MAX_BITS-1:0] masked,
    output logic [MAX_BITS-1:0] ordered
);
    localparam int SH_W = LEN_W + 1;

    logic [SH_W-1:0]     unused_sh;
    logic [MAX_BITS-1:0] rev_full;

    // Unused-width amount: MAX_BITS minus the word length.
    assign unused_sh = SH_W'(MAX_BITS - 1) - {1'b0, lenm1};

    // Clear every bit at or above the programmed length.
    assign masked = data & ({MAX_BITS{1'b1}} >> unused_sh);

    // Mirror the full-width word bit by bit.
    for (genvar g = 0; g < MAX_BITS; g++) begin : g_rev
        assign rev_full[g] = masked[MAX_BITS-1-g];
    end

    // Pick the send order; the mirrored word is brought back down to bit 0.
    always_comb begin
        if (lsb_first) ordered = masked;
        else           ordered = rev_full >> unused_sh;
    end
endmodule

// File: rtl/pcm_ser_parity.sv
`timescale 1ns/1ps
// Module: pcm_ser_parity
// Computes the parity bit of the masked data bits.
// Assumes: bits above the length are already zero.
module pcm_ser_parity #(
    parameter int MAX_BITS = 32
) (
    input  logic [MAX_BITS-1:0] masked,
    input  logic                odd_sel,
    output logic                par_bit
);
    // XOR reduction, inverted for odd parity.
    assign par_bit = (^masked) ^ odd_sel;
endmodule

// File: rtl/pcm_ser_frame_build.sv
`timescale 1ns/1ps
// Module: pcm_ser_frame_build
// Places the parity bit before or after the ordered data, or leaves it out,
// and reports how many bit times the word will occupy.
// Assumes: 'ordered' is zero above the word length.
module pcm_ser_frame_build
    import pcm_ser_pkg::*;
#(
    parameter int MAX_BITS = 32,
    localparam int LEN_W   = $clog2(MAX_BITS),
    localparam int SEQ_W   = MAX_BITS + 1,
    localparam int CNT_W   = $clog2(SEQ_W + 1)
) (
    input  logic [MAX_BITS-1:0] ordered,
    input  logic                par_bit,
    input  logic [LEN_W-1:0]    lenm1,
    input  par_mode_e           par_mode,
    output logic [SEQ_W-1:0]    seq,
    output logic [CNT_W-1:0]    total
);
    logic [CNT_W-1:0] data_len;

    // Number of data bits in the word.
    assign data_len = CNT_W'(lenm1) + CNT_W'(1);

    // Assemble the bit sequence, first bit at index 0.
    always_comb begin
        unique case (par_mode)
            PAR_LEAD: begin
                seq   = {ordered, par_bit};
                total = data_len + CNT_W'(1);
            end
            PAR_TRAIL: begin
                seq   = {1'b0, ordered} | (SEQ_W'(par_bit) << data_len);
                total = data_len + CNT_W'(1);
            end
            default: begin
                seq   = {1'b0, ordered};
                total = data_len;
            end
        endcase
    end
endmodule

// File: rtl/pcm_ser_shifter.sv
`timescale 1ns/1ps
// Module: pcm_ser_shifter
// Holds the bit sequence of the word in flight and steps it one bit per
// enable. It loads the next word on the enable that ends the current one.
// Assumes: seq/total are valid whenever load_valid is high.
module pcm_ser_shifter #(
    parameter int SEQ_W = 33,
    localparam int CNT_W = $clog2(SEQ_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             load_valid,
    input  logic [SEQ_W-1:0] seq,
    input  logic [CNT_W-1:0] total,
    output logic             load_ready,
    output logic             ser_data,
    output logic             ser_valid,
    output logic             ser_clk,
    output logic [CNT_W-1:0] bits_left
);
    logic [SEQ_W-1:0] sreg;
    logic             at_end;

    // Idle or showing the final bit of the word.
    assign at_end     = (bits_left < CNT_W'(2));
    assign load_ready = bit_en && at_end;

    // Step, load or clear the bit sequence on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg      <= '0;
            bits_left <= '0;
            ser_clk   <= 1'b0;
        end else begin
            ser_clk <= 1'b0;
            if (bit_en) begin
                if (at_end) begin
                    if (load_valid) begin
                        sreg      <= seq;
                        bits_left <= total;
                        ser_clk   <= 1'b1;
                    end else begin
                        sreg      <= '0;
                        bits_left <= '0;
                    end
                end else begin
                    sreg      <= sreg >> 1;
                    bits_left <= bits_left - CNT_W'(1);
                    ser_clk   <= 1'b1;
                end
            end
        end
    end

    assign ser_data  = sreg[0];
    assign ser_valid = (bits_left != '0);

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ser_data) && $stable(ser_valid)))
        else $error("line moved without enable"); // R5
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bits_left > CNT_W'(1)) |=> ser_valid)
        else $error("gap inside word"); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> (!ser_data && !ser_clk))
        else $error("idle line not quiet"); // R7
    AST_CLK_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $past(bit_en))
        else $error("bit clock without enable"); // R8
endmodule

// File: rtl/pcm_word_serializer.sv
`timescale 1ns/1ps
// Module: pcm_word_serializer (top)
// Serializes one descriptor-tagged word per handshake into an NRZ-L stream
// with an aligned bit clock pulse. Length, order and parity vary per word.
// Assumes: bit_en is a one-cycle pulse per bit time; the producer holds its
// word until word_ready is seen with word_valid.
module pcm_word_serializer
    import pcm_ser_pkg::*;
#(
    parameter int MAX_BITS = 32,
    localparam int LEN_W   = $clog2(MAX_BITS),
    localparam int SEQ_W   = MAX_BITS + 1,
    localparam int CNT_W   = $clog2(SEQ_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                word_valid,
    input  logic [MAX_BITS-1:0] word_data,
    input  logic [LEN_W-1:0]    word_lenm1,
    input  logic                word_lsb_first,
    input  logic [1:0]          word_par_mode,
    input  logic                word_par_odd,
    output logic                word_ready,
    output logic                ser_data,
    output logic                ser_valid,
    output logic                ser_clk
);
    logic [MAX_BITS-1:0] masked;
    logic [MAX_BITS-1:0] ordered;
    logic                par_bit;
    logic [SEQ_W-1:0]    seq;
    logic [CNT_W-1:0]    total;
    logic [CNT_W-1:0]    bits_left;
    par_mode_e           mode;

    assign mode = par_mode_e'(word_par_mode);

    pcm_ser_order #(.MAX_BITS(MAX_BITS)) order_i (
        .data      (word_data),
        .lenm1     (word_lenm1),
        .lsb_first (word_lsb_first),
        .masked    (masked),
        .ordered   (ordered)
    );

    pcm_ser_parity #(.MAX_BITS(MAX_BITS)) parity_i (
        .masked  (masked),
        .odd_sel (word_par_odd),
        .par_bit (par_bit)
    );

    pcm_ser_frame_build #(.MAX_BITS(MAX_BITS)) build_i (
        .ordered  (ordered),
        .par_bit  (par_bit),
        .lenm1    (word_lenm1),
        .par_mode (mode),
        .seq      (seq),
        .total    (total)
    );

    pcm_ser_shifter #(.SEQ_W(SEQ_W)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .load_valid (word_valid),
        .seq        (seq),
        .total      (total),
        .load_ready (word_ready),
        .ser_data   (ser_data),
        .ser_valid  (ser_valid),
        .ser_clk    (ser_clk),
        .bits_left  (bits_left)
    );

    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> bit_en)
        else $error("ready outside enable"); // R6
    AST_SLOTS_NO_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && (word_par_mode == 2'd0 || word_par_mode == 2'd3))
        |=> (bits_left == $past(CNT_W'(word_lenm1) + CNT_W'(1))))
        else $error("wrong slot count without parity"); // R3
    AST_SLOTS_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && (word_par_mode == 2'd1 || word_par_mode == 2'd2))
        |=> (bits_left == $past(CNT_W'(word_lenm1) + CNT_W'(2))))
        else $error("wrong slot count with parity"); // R3
    AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> (ser_valid && ser_clk))
        else $error("accepted word not on line"); // R5
endmodule

// File: tb/pcm_word_serializer_tb.sv
`timescale 1ns/1ps
// Bench: table of words walked back to back, then directed tests.
module pcm_word_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic [4:0]  word_lenm1 = '0;
    logic        word_lsb_first = 1'b0;
    logic [1:0]  word_par_mode = '0;
    logic        word_par_odd = 1'b0;
    logic        word_ready, ser_data, ser_valid, ser_clk;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pcm_word_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_valid(word_valid),
        .word_data(word_data), .word_lenm1(word_lenm1),
        .word_lsb_first(word_lsb_first), .word_par_mode(word_par_mode),
        .word_par_odd(word_par_odd), .word_ready(word_ready),
        .ser_data(ser_data), .ser_valid(ser_valid), .ser_clk(ser_clk)
    );

    localparam int NV = 8;
    localparam logic [31:0] V_DATA [NV] = '{32'h0000_00A5, 32'hFFFF_FF01, 32'h0000_0001,
        32'hDEAD_BEEF, 32'h8000_0001, 32'h0000_0000, 32'h0000_3C5A, 32'hFFFF_FFFE};
    localparam logic [4:0] V_LENM1 [NV] = '{5'd7, 5'd3, 5'd0, 5'd31, 5'd31, 5'd0, 5'd15, 5'd0};
    localparam logic V_LSB [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [1:0] V_PM [NV] = '{2'd2, 2'd1, 2'd0, 2'd2, 2'd1, 2'd1, 2'd3, 2'd2};
    localparam logic V_ODD [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected line sequence from the requirements (R1..R4).
    function automatic void model(input logic [31:0] d, input logic [4:0] lm1,
                                  input logic lsb, input logic [1:0] pm, input logic odd,
                                  output logic [32:0] s, output int n);
        int len;
        int ones;
        logic p;
        len = int'(lm1) + 1;
        ones = 0;
        s = '0;
        n = 0;
        for (int i = 0; i < len; i++) ones += int'(d[i]);
        p = odd ? (ones % 2 == 0) : (ones % 2 == 1);
        if (pm == 2'd1) begin s[n] = p; n++; end
        for (int i = 0; i < len; i++) begin
            s[n] = lsb ? d[i] : d[len-1-i];
            n++;
        end
        if (pm == 2'd2) begin s[n] = p; n++; end
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [32:0] exp_s;
        logic [32:0] got;
        int n;
        bit side_ok;
        // Reset state, R9 / R7
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!ser_valid && !ser_data && !ser_clk, "R9", "reset idle", {ser_valid, ser_data, ser_clk}, 0);
        bit_en = 1'b1;
        #1;
        check(word_ready == 1'b1, "R9", "ready while idle", word_ready, 1);
        bit_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: words back to back (R1 R2 R3 R4 R5 R6 R8)
        for (int k = 0; k < NV; k++) begin
            model(V_DATA[k], V_LENM1[k], V_LSB[k], V_PM[k], V_ODD[k], exp_s, n);
            got = '0;
            side_ok = 1'b1;
            for (int b = 0; b < n; b++) begin
                bit_en = 1'b1;
                if (b == 0) begin
                    word_valid = 1'b1;
                    word_data = V_DATA[k];
                    word_lenm1 = V_LENM1[k];
                    word_lsb_first = V_LSB[k];
                    word_par_mode = V_PM[k];
                    word_par_odd = V_ODD[k];
                end
                #1;
                if (b == 0) check(word_ready == 1'b1, "R6", "ready at word end", word_ready, 1);
                else if (word_ready) side_ok = 1'b0;
                @(posedge clk);
                @(negedge clk);
                bit_en = 1'b0;
                word_valid = 1'b0;
                word_data = 32'h5A5A_5A5A;
                got[b] = ser_data;
                if (!ser_clk || !ser_valid) side_ok = 1'b0;
                @(negedge clk);
                if (ser_clk || ser_data != got[b] || !ser_valid) side_ok = 1'b0;
            end
            check(got == exp_s, "R1 R2 R3 R4", $sformatf("word %0d stream", k), 64'(got), 64'(exp_s));
            check(side_ok, "R5 R8", $sformatf("word %0d pacing", k), side_ok, 1);
        end

        // End with no next word: line goes quiet, R7
        bit_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0;
        check(!ser_valid && !ser_data && !ser_clk, "R7", "idle after last word",
              {ser_valid, ser_data, ser_clk}, 0);

        // Long hold with no enables keeps the bit, R5
        bit_en = 1'b1; word_valid = 1'b1; word_data = 32'h1; word_lenm1 = 5'd3;
        word_lsb_first = 1'b1; word_par_mode = 2'd0; word_par_odd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0; word_valid = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(ser_data && ser_valid && !ser_clk, "R5", "hold without enable",
              {ser_data, ser_valid, ser_clk}, 3'b110);

        // Mid-word reset clears the line, R9
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(!ser_valid && !ser_data, "R9", "reset mid word", {ser_valid, ser_data}, 0);
        bit_en = 1'b1;
        #1;
        check(word_ready == 1'b1, "R6", "ready after reset", word_ready, 1);
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0;
        check(!ser_valid, "R7", "no word taken without valid", ser_valid, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule